// File: doc/BRIEF.md
# Last-Read Capture and Restore Sequencer

This block sits beside the second port of a 72-bit single-cycle-latency memory. It watches the user requests on that port and keeps a shadow copy of the most recent user read: the address and the data that came back. A backdoor controller can then ask it to restore that read. The block takes over the port's request bus and runs a fixed four-access sequence at the shadowed address. The sequence leaves the memory holding its current contents. It also leaves the user-visible read output showing the value the user last saw.

During the sequence, the block first fetches the word that is stored now and keeps it as the newer value. It writes the shadowed old data into memory and reads it back, so the port output carries the old word again. It then writes the newer value back. An override register holds the old word on the output until the user issues another read. A build-time parameter removes the feature entirely. When the feature is removed, restore requests draw no response at all.

Top module: `lastread_restore`

## Requirements
- R1: While reset is held and just after it, `rstrDone`, `seqReq` and `ovrActive` are low, and `doutB` follows `memRdData`.
- R2: A user read is `usrEn`=1 with `usrWr`=0 while `bkMode`=0 and no restore is running. It records `usrAddr`, and it records `memRdData` of the following cycle as the old data. User writes, and user reads made while `bkMode`=1, leave the record unchanged.
- R3: A restore request is `rstrReq` high in cycle c while a record exists. It produces a read (`seqReq`=1, `seqWr`=0) of the recorded address in cycle c+1. The word returned in cycle c+2 is kept as the newer value.
- R4: In cycle c+4 the block writes the recorded old data to the recorded address (`seqReq`=1, `seqWr`=1, `seqWrData` = old data).
- R5: In cycle c+7 the block reads the recorded address again. From cycle c+9 onward, `ovrActive` is 1 and `doutB` shows the word returned in cycle c+8, which is the old data.
- R6: In cycle c+10 the block writes the newer value to the recorded address. Memory therefore ends the restore with its pre-restore contents.
- R7: `rstrDone` is high for exactly one cycle, in cycle c+15. Exactly four port accesses occur between the request and done.
- R8: A restore request made while no user read has been recorded raises `rstrDone` in cycle c+1 and makes no port access.
- R9: After a restore, `doutB` keeps the old word even while `memRdData` changes, including after user writes. The next user read clears `ovrActive`, and from the following cycle `doutB` again follows `memRdData`.
- R10: When `ENABLE_RESTORE` = 0, `rstrReq` has no effect: `rstrDone` and `seqReq` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bkMode | input | 1 | Backdoor session active; freezes capture |
| usrEn | input | 1 | User port enable (snooped) |
| usrWr | input | 1 | User port write select, 1 = write (snooped) |
| usrAddr | input | ADDR_W | User port address (snooped) |
| memRdData | input | DATA_W | Memory read data, valid the cycle after a read |
| rstrReq | input | 1 | Restore request from the backdoor controller |
| rstrDone | output | 1 | One-cycle restore completion pulse |
| seqReq | output | 1 | Sequencer owns the memory port this cycle |
| seqWr | output | 1 | Sequencer access is a write |
| seqAddr | output | ADDR_W | Sequencer access address |
| seqWrData | output | DATA_W | Sequencer write data |
| doutB | output | DATA_W | User-visible read output with override |
| ovrActive | output | 1 | Override value is driving `doutB` |

## Verification
The restore is run three times, each with a different old/new word pair and at two different addresses. This rules out a datapath that swaps the old and new words or keeps a stale address. The bench memory returns the written word after each write. Because of that, an output that lost its override would show the newer word, not the old one. Writes and backdoor-mode reads are placed between capture and restore, so a capture that is not frozen shows up as a wrong address or wrong data. A request made before any capture, and a second build with the feature removed, separate the quick-completion path from the path where nothing responds.

// File: rtl/lrr_pkg.sv
`timescale 1ns/1ps
package lrr_pkg;
  localparam int unsigned RESTORE_LAT = 15;
  localparam int unsigned CNT_W = $clog2(RESTORE_LAT);

  // schedule offsets, counted from the first busy cycle (request cycle + 1)
  localparam logic [CNT_W-1:0] STEP_RD_NEW  = CNT_W'(0);
  localparam logic [CNT_W-1:0] STEP_HOLD    = CNT_W'(1);
  localparam logic [CNT_W-1:0] STEP_WR_OLD  = CNT_W'(3);
  localparam logic [CNT_W-1:0] STEP_RD_OLD  = CNT_W'(6);
  localparam logic [CNT_W-1:0] STEP_LOAD    = CNT_W'(7);
  localparam logic [CNT_W-1:0] STEP_WR_NEW  = CNT_W'(9);
  localparam logic [CNT_W-1:0] STEP_LAST    = CNT_W'(RESTORE_LAT - 1);

  typedef struct packed {
    logic capAddr;
    logic capData;
    logic holdNew;
    logic loadOvr;
    logic clrOvr;
    logic selNew;
  } dpStrobe_t;
endpackage

// File: rtl/lrr_ctrl.sv
`timescale 1ns/1ps
module lrr_ctrl
  import lrr_pkg::*;
#(
  parameter bit ENABLE_RESTORE = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bkMode,
  input  logic      usrEn,
  input  logic      usrWr,
  input  logic      rstrReq,
  output logic      busy,
  output logic      rstrDone,
  output logic      seqReq,
  output logic      seqWr,
  output dpStrobe_t strb
);
  logic [CNT_W-1:0] cnt;
  logic pendCap;
  logic capValid;
  logic quickDone;
  logic reqSeen;
  logic userRead;

  assign reqSeen  = ENABLE_RESTORE ? rstrReq : 1'b0;
  assign userRead = usrEn & ~usrWr & ~bkMode & ~busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      cnt       <= '0;
      pendCap   <= 1'b0;
      capValid  <= 1'b0;
      quickDone <= 1'b0;
    end else begin
      pendCap   <= userRead;
      if (pendCap) capValid <= 1'b1;
      quickDone <= reqSeen & ~busy & ~capValid;
      if (busy) begin
        if (cnt == STEP_LAST) busy <= 1'b0;
        cnt <= cnt + 1'b1;
      end else if (reqSeen && capValid) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end
  end

  always_comb begin
    seqWr    = busy & ((cnt == STEP_WR_OLD) | (cnt == STEP_WR_NEW));
    seqReq   = seqWr | (busy & ((cnt == STEP_RD_NEW) | (cnt == STEP_RD_OLD)));
    rstrDone = (busy & (cnt == STEP_LAST)) | quickDone;
    strb.capAddr = userRead;
    strb.capData = pendCap;
    strb.holdNew = busy & (cnt == STEP_HOLD);
    strb.loadOvr = busy & (cnt == STEP_LOAD);
    strb.clrOvr  = userRead;
    strb.selNew  = (cnt == STEP_WR_NEW);
  end
endmodule

// File: rtl/lrr_dpath.sv
`timescale 1ns/1ps
module lrr_dpath
  import lrr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 72
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] usrAddr,
  input  logic [DATA_W-1:0] memRdData,
  input  dpStrobe_t         strb,
  output logic [ADDR_W-1:0] seqAddr,
  output logic [DATA_W-1:0] seqWrData,
  output logic [DATA_W-1:0] doutB,
  output logic              ovrActive
);
  logic [ADDR_W-1:0] lastAddr;
  logic [DATA_W-1:0] lastData;
  logic [DATA_W-1:0] newData;
  logic [DATA_W-1:0] ovrData;
  logic              ovrOn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastAddr <= '0;
      lastData <= '0;
      newData  <= '0;
      ovrData  <= '0;
      ovrOn    <= 1'b0;
    end else begin
      if (strb.capAddr) lastAddr <= usrAddr;
      if (strb.capData) lastData <= memRdData;
      if (strb.holdNew) newData  <= memRdData;
      if (strb.clrOvr) begin
        ovrOn <= 1'b0;
      end else if (strb.loadOvr) begin
        ovrOn   <= 1'b1;
        ovrData <= memRdData;
      end
    end
  end

  assign seqAddr   = lastAddr;
  assign seqWrData = strb.selNew ? newData : lastData;
  assign doutB     = ovrOn ? ovrData : memRdData;
  assign ovrActive = ovrOn;
endmodule

// File: rtl/lastread_restore.sv
`timescale 1ns/1ps
module lastread_restore
  import lrr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 72,
  parameter bit ENABLE_RESTORE  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bkMode,
  input  logic              usrEn,
  input  logic              usrWr,
  input  logic [ADDR_W-1:0] usrAddr,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              rstrReq,
  output logic              rstrDone,
  output logic              seqReq,
  output logic              seqWr,
  output logic [ADDR_W-1:0] seqAddr,
  output logic [DATA_W-1:0] seqWrData,
  output logic [DATA_W-1:0] doutB,
  output logic              ovrActive
);
  dpStrobe_t strb;
  logic      busyW;

  lrr_ctrl #(.ENABLE_RESTORE(ENABLE_RESTORE)) u_ctrl (
    .clk(clk), .rstN(rstN), .bkMode(bkMode), .usrEn(usrEn), .usrWr(usrWr),
    .rstrReq(rstrReq), .busy(busyW), .rstrDone(rstrDone), .seqReq(seqReq),
    .seqWr(seqWr), .strb(strb)
  );

  lrr_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .usrAddr(usrAddr), .memRdData(memRdData),
    .strb(strb), .seqAddr(seqAddr), .seqWrData(seqWrData), .doutB(doutB),
    .ovrActive(ovrActive)
  );
endmodule

// File: rtl/lrr_checker.sv
`timescale 1ns/1ps
module lrr_checker #(
  parameter int unsigned ADDR_W = 10,
  parameter bit ENABLE_RESTORE  = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              bkMode,
  input logic              usrEn,
  input logic              usrWr,
  input logic              busy,
  input logic              rstrDone,
  input logic              seqReq,
  input logic              seqWr,
  input logic [ADDR_W-1:0] seqAddr,
  input logic              ovrActive
);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    rstrDone |=> !rstrDone);

  a_r4_write_owns_port: assert property (@(posedge clk) disable iff (!rstN)
    seqWr |-> seqReq);

  a_r6_addr_steady: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(seqAddr));

  a_r9_ovr_clear: assert property (@(posedge clk) disable iff (!rstN)
    (usrEn && !usrWr && !bkMode && !busy) |=> !ovrActive);

  always_comb begin
    if (rstN && !ENABLE_RESTORE) begin
      a_r10_off_silent: assert (!seqReq && !rstrDone);
    end
  end
endmodule

bind lastread_restore lrr_checker #(.ADDR_W(ADDR_W), .ENABLE_RESTORE(ENABLE_RESTORE)) u_chk (
  .clk(clk), .rstN(rstN), .bkMode(bkMode), .usrEn(usrEn), .usrWr(usrWr),
  .busy(busyW), .rstrDone(rstrDone), .seqReq(seqReq), .seqWr(seqWr),
  .seqAddr(seqAddr), .ovrActive(ovrActive)
);

// File: tb/test_lastread_restore.sv
`timescale 1ns/1ps
module test_lastread_restore;
  localparam int AW = 10;
  localparam int DW = 72;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          bkMode = 1'b0;
  logic          usrEn = 1'b0;
  logic          usrWr = 1'b0;
  logic [AW-1:0] usrAddr = '0;
  logic [DW-1:0] usrWrData = '0;
  logic          rstrReq = 1'b0;
  logic [DW-1:0] rdQ = '0;
  logic          rstrDone, seqReq, seqWr, ovrActive;
  logic [AW-1:0] seqAddr;
  logic [DW-1:0] seqWrData, doutB;
  logic          offDone, offSeqReq, offSeqWr, offOvr;
  logic [AW-1:0] offSeqAddr;
  logic [DW-1:0] offSeqWrData, offDoutB;

  lastread_restore #(.ADDR_W(AW), .DATA_W(DW)) i_lastread_restore (
    .clk(clk), .rstN(rstN), .bkMode(bkMode), .usrEn(usrEn), .usrWr(usrWr),
    .usrAddr(usrAddr), .memRdData(rdQ), .rstrReq(rstrReq), .rstrDone(rstrDone),
    .seqReq(seqReq), .seqWr(seqWr), .seqAddr(seqAddr), .seqWrData(seqWrData),
    .doutB(doutB), .ovrActive(ovrActive)
  );

  lastread_restore #(.ADDR_W(AW), .DATA_W(DW), .ENABLE_RESTORE(1'b0)) i_lastread_restore_off (
    .clk(clk), .rstN(rstN), .bkMode(bkMode), .usrEn(usrEn), .usrWr(usrWr),
    .usrAddr(usrAddr), .memRdData(rdQ), .rstrReq(rstrReq), .rstrDone(offDone),
    .seqReq(offSeqReq), .seqWr(offSeqWr), .seqAddr(offSeqAddr), .seqWrData(offSeqWrData),
    .doutB(offDoutB), .ovrActive(offOvr)
  );

  // memory model: one-cycle read latency, a write also returns the written word
  logic [DW-1:0] mem [1 << AW];
  initial for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
  always @(posedge clk) begin
    if (seqReq) begin
      if (seqWr) begin mem[seqAddr] <= seqWrData; rdQ <= seqWrData; end
      else rdQ <= mem[seqAddr];
    end else if (usrEn) begin
      if (usrWr) begin mem[usrAddr] <= usrWrData; rdQ <= usrWrData; end
      else rdQ <= mem[usrAddr];
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  typedef struct {
    int            when;
    bit            wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         req;
  } item_t;
  item_t expQ[$];
  int    doneQ[$];

  // monitor: pops expected accesses and done pulses as they appear
  always @(negedge clk) begin
    if (rstN) begin
      if (seqReq) begin
        if (expQ.size() == 0) chk(1'b0, "R7", "unexpected access at addr", DW'(seqAddr), '0);
        else begin
          item_t it;
          it = expQ.pop_front();
          chk(cyc == it.when, it.req, "access cycle", DW'(cyc), DW'(it.when));
          chk(seqWr == it.wr, it.req, "access kind", DW'(seqWr), DW'(it.wr));
          chk(seqAddr == it.addr, it.req, "access addr", DW'(seqAddr), DW'(it.addr));
          if (it.wr) chk(seqWrData == it.data, it.req, "write data", seqWrData, it.data);
        end
      end
      if (rstrDone) begin
        if (doneQ.size() == 0) chk(1'b0, "R7", "unexpected done at cycle", DW'(cyc), '0);
        else begin
          int w;
          w = doneQ.pop_front();
          chk(cyc == w, "R7", "done cycle", DW'(cyc), DW'(w));
        end
      end
      if (offSeqReq || offDone) chk(1'b0, "R10", "disabled build responded", DW'({offSeqReq, offDone}), '0);
    end
  end

  task automatic userWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    usrEn = 1'b1; usrWr = 1'b1; usrAddr = a; usrWrData = d;
    @(negedge clk);
    usrEn = 1'b0; usrWr = 1'b0;
  endtask

  task automatic userRead(input logic [AW-1:0] a);
    @(negedge clk);
    usrEn = 1'b1; usrWr = 1'b0; usrAddr = a;
    @(negedge clk);
    usrEn = 1'b0;
  endtask

  // driver: pushes the expected schedule, then pulses the request
  task automatic restore(input bit hasCap, input logic [AW-1:0] a,
                         input logic [DW-1:0] oldV, input logic [DW-1:0] newV);
    int c;
    @(negedge clk);
    rstrReq = 1'b1;
    c = cyc;
    if (hasCap) begin
      expQ.push_back('{c + 1,  1'b0, a, '0,   "R3"});
      expQ.push_back('{c + 4,  1'b1, a, oldV, "R4"});
      expQ.push_back('{c + 7,  1'b0, a, '0,   "R5"});
      expQ.push_back('{c + 10, 1'b1, a, newV, "R6"});
      doneQ.push_back(c + 15);
    end else begin
      doneQ.push_back(c + 1);   // R8 quick completion
    end
    @(negedge clk);
    rstrReq = 1'b0;
    repeat (17) @(negedge clk);
    chk(expQ.size() == 0, "R7", "accesses missing", DW'(expQ.size()), '0);
    chk(doneQ.size() == 0, "R7", "done missing", DW'(doneQ.size()), '0);
  endtask

  localparam logic [AW-1:0] ADR_A = 10'h155;
  localparam logic [AW-1:0] ADR_B = 10'h0AA;
  localparam logic [DW-1:0] D0 = 72'hA1_0123_4567_89AB_CDEF;
  localparam logic [DW-1:0] D1 = 72'h5E_FEDC_BA98_7654_3210;
  localparam logic [DW-1:0] D2 = 72'h3C_0F0F_0F0F_F0F0_F0F0;
  localparam logic [DW-1:0] D3 = 72'hC3_AAAA_5555_AAAA_5555;
  localparam logic [DW-1:0] D4 = 72'h99_1357_9BDF_2468_ACE0;

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state while reset is held
    chk(!rstrDone && !seqReq, "R1", "done/req in reset", DW'({rstrDone, seqReq}), '0);
    chk(!ovrActive, "R1", "override in reset", DW'(ovrActive), '0);
    rstN = 1'b1;
    @(negedge clk);
    chk(doutB == rdQ, "R1", "doutB follows memory", doutB, rdQ);

    // R8: no record yet
    restore(1'b0, '0, '0, '0);
    userWrite(ADR_A, D0);
    userWrite(ADR_B, D2);
    // R2: writes do not record; still quick completion
    restore(1'b0, '0, '0, '0);

    // pattern 1
    userRead(ADR_A);
    chk(doutB == D0, "R2", "user read data", doutB, D0);
    userWrite(ADR_A, D1);
    bkMode = 1'b1;
    userRead(ADR_B);            // R2: frozen during backdoor mode
    restore(1'b1, ADR_A, D0, D1);
    chk(ovrActive, "R5", "override active", DW'(ovrActive), 1);
    chk(doutB == D0, "R5", "old value shown", doutB, D0);
    chk(rdQ == D1, "R9", "memory output moved on", rdQ, D1);
    bkMode = 1'b0;
    userWrite(ADR_B, D2);
    chk(doutB == D0, "R9", "override held over user write", doutB, D0);
    userRead(ADR_A);
    chk(!ovrActive, "R9", "override cleared by read", DW'(ovrActive), '0);
    chk(doutB == D1, "R6", "memory holds newer value", doutB, D1);

    // pattern 2: same address, new pair
    userWrite(ADR_A, D3);
    restore(1'b1, ADR_A, D1, D3);
    chk(doutB == D1, "R5", "old value shown p2", doutB, D1);

    // pattern 3: other address
    userRead(ADR_B);
    chk(doutB == D2, "R9", "read after override", doutB, D2);
    userWrite(ADR_B, D4);
    restore(1'b1, ADR_B, D2, D4);
    chk(doutB == D2, "R5", "old value shown p3", doutB, D2);
    userRead(ADR_B);
    chk(doutB == D4, "R6", "memory holds newer value p3", doutB, D4);
    userRead(ADR_A);
    chk(doutB == D3, "R6", "other word untouched", doutB, D3);
    chk(!offOvr && !offDone, "R10", "disabled build idle", DW'({offOvr, offDone}), '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule